// File: doc/BRIEF.md
# Quadrature Bitstream Correlator with Table-Driven Stimulus

This block measures how strongly a group of 1-bit converter streams correlates with a reference tone. Each clock it counts the enabled input bits (each one optionally inverted) to form a small unsigned sample. It multiplies that sample by a signed sine value and a signed cosine value taken from an external lookup table. The two products then pass through separate two-stage integrator chains. A phase accumulator, advanced by a programmable frequency word, forms the table address. The same table word also carries two bytes that are turned into offset-binary DAC codes, so one table drives both the stimulus and the detector.

The first integrator stage either holds the latest product (single-integration mode) or sums the products (double-integration mode). Changing the mode clears that stage. Software can therefore flush it by toggling the mode away and straight back. The second stage adds the first stage on every clock. A snapshot strobe copies the second-stage totals to the result outputs and restarts them from zero.

Top module: `corr_quad_top`

## Requirements
- R1: The sample is the count of inputs k with adc_en_i[k]=1 whose value adc_bits_i[k] XOR adc_inv_i[k] is 1; a disabled input has no effect on the sample.
- R2: tbl_addr_o is the upper ADDR_W bits of a PHASE_W-bit phase register that starts at zero and gains freq_i on each clock.
- R3: The sine product is the sample times the signed byte tbl_data_i[31:24], and the cosine product is the sample times the signed byte tbl_data_i[23:16], both using the table word at the current address.
- R4: With mode_i=0 (single), each first integrator is loaded with its latest product, without accumulation.
- R5: With mode_i=1 (double), each first integrator adds its latest product to its previous value.
- R6: On every clock, each second integrator (ACC_W bits, wrapping) adds the sign-extended value its first integrator held before that clock.
- R7: On a clock where mode_i differs from the mode registered on the previous clock, both first integrators are cleared to zero instead of being updated.
- R8: When snap_i is high at a clock, res_sin_o and res_cos_o take the second-integrator values from before that clock and the second integrators restart at zero; otherwise the results hold.
- R9: One clock after the table word is presented, dac_sin_o is tbl_data_i[15:8] with its MSB inverted and dac_cos_o is tbl_data_i[7:0] with its MSB inverted, which maps signed -127..+127 to 1..255.
- R10: Reset gives phase 0, zero integrators and results, single mode, and DAC outputs of 8'h80.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| adc_bits_i | input | NUM_IN | 1-bit converter streams |
| adc_en_i | input | NUM_IN | Per-input enable |
| adc_inv_i | input | NUM_IN | Per-input polarity inversion |
| freq_i | input | PHASE_W | Phase increment per clock |
| mode_i | input | 1 | 0 single integration, 1 double integration |
| snap_i | input | 1 | Snapshot and clear of second integrators |
| tbl_addr_o | output | ADDR_W | Table address |
| tbl_data_i | input | 32 | Table word at tbl_addr_o, same cycle |
| res_sin_o | output | ACC_W | Captured sine total |
| res_cos_o | output | ACC_W | Captured cosine total |
| dac_sin_o | output | 8 | Offset-binary sine DAC code |
| dac_cos_o | output | 8 | Offset-binary cosine DAC code |

## Verification
The bench uses the default parameters: four inputs, a 32-bit phase, an 8-bit address, 24-bit first and 32-bit second integrators. With four inputs, every combination of enable, polarity and bit value can be reached, including the full sample of 4. The 8-bit address lets a large frequency word walk through distinct table entries in a few clocks. The table is a computed function of the address, so each product can be predicted. The integrator widths hold every sum the short runs build without wrapping, so the results isolate the order of the mode, clear and snapshot operations.

// File: rtl/corr_pkg.sv
package corr_pkg;
    typedef enum logic {
        MODE_SINGLE = 1'b0,
        MODE_DOUBLE = 1'b1
    } corr_mode_e;
endpackage

// File: rtl/corr_sample_sum.sv
module corr_sample_sum #(
    parameter int NUM_IN = 4,
    parameter int SUM_W  = $clog2(NUM_IN + 1)
) (
    input  logic [NUM_IN-1:0] bits_i,
    input  logic [NUM_IN-1:0] en_i,
    input  logic [NUM_IN-1:0] inv_i,
    output logic [SUM_W-1:0]  sum_o
);
    logic [NUM_IN-1:0] term;

    for (genvar k = 0; k < NUM_IN; k++) begin : g_term
        assign term[k] = en_i[k] & (bits_i[k] ^ inv_i[k]);
    end

    always_comb begin
        sum_o = '0;
        for (int k = 0; k < NUM_IN; k++) begin
            sum_o = sum_o + SUM_W'(term[k]);
        end
    end
endmodule

// File: rtl/corr_integ.sv
module corr_integ
    import corr_pkg::*;
#(
    parameter int SUM_W  = 3,
    parameter int INT1_W = 24,
    parameter int ACC_W  = 32
) (
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic [SUM_W-1:0]         sample_i,
    input  logic signed [7:0]        coef_i,
    input  corr_mode_e               mode_i,
    input  logic                     clear1_i,
    input  logic                     snap_i,
    output logic [ACC_W-1:0]         result_o,
    output logic signed [INT1_W-1:0] int1_o,
    output logic [ACC_W-1:0]         int2_o
);
    localparam int PROD_W = SUM_W + 9;

    typedef struct packed {
        logic [INT1_W-1:0] int1;
        logic [ACC_W-1:0]  int2;
        logic [ACC_W-1:0]  res;
    } integ_t;

    integ_t state_d, state_q;
    logic signed [PROD_W-1:0] prod;

    always_comb begin
        prod = $signed({1'b0, sample_i}) * PROD_W'(coef_i);
        state_d = state_q;
        if (clear1_i) begin
            state_d.int1 = '0;
        end else if (mode_i == MODE_SINGLE) begin
            state_d.int1 = INT1_W'(prod);
        end else begin
            state_d.int1 = state_q.int1 + INT1_W'(prod);
        end
        if (snap_i) begin
            state_d.res  = state_q.int2;
            state_d.int2 = '0;
        end else begin
            state_d.int2 = state_q.int2 + ACC_W'($signed(state_q.int1));
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign result_o = state_q.res;
    assign int1_o   = $signed(state_q.int1);
    assign int2_o   = state_q.int2;
endmodule

// File: rtl/corr_quad_top.sv
module corr_quad_top
    import corr_pkg::*;
#(
    parameter int NUM_IN  = 4,
    parameter int PHASE_W = 32,
    parameter int ADDR_W  = 8,
    parameter int INT1_W  = 24,
    parameter int ACC_W   = 32
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [NUM_IN-1:0]  adc_bits_i,
    input  logic [NUM_IN-1:0]  adc_en_i,
    input  logic [NUM_IN-1:0]  adc_inv_i,
    input  logic [PHASE_W-1:0] freq_i,
    input  logic               mode_i,
    input  logic               snap_i,
    output logic [ADDR_W-1:0]  tbl_addr_o,
    input  logic [31:0]        tbl_data_i,
    output logic [ACC_W-1:0]   res_sin_o,
    output logic [ACC_W-1:0]   res_cos_o,
    output logic [7:0]         dac_sin_o,
    output logic [7:0]         dac_cos_o
);
    localparam int SUM_W = $clog2(NUM_IN + 1);

    typedef struct packed {
        logic [PHASE_W-1:0] phase;
        corr_mode_e         mode;
        logic [7:0]         dac_sin;
        logic [7:0]         dac_cos;
    } top_t;

    top_t state_d, state_q;
    logic [SUM_W-1:0] sample;
    logic             mode_chg;
    corr_mode_e       mode_now;
    logic signed [INT1_W-1:0] int1_sin, int1_cos;
    logic [ACC_W-1:0]         int2_sin, int2_cos;

    assign mode_now = corr_mode_e'(mode_i);
    assign mode_chg = (mode_now != state_q.mode);

    corr_sample_sum #(.NUM_IN(NUM_IN), .SUM_W(SUM_W)) i_sum (
        .bits_i (adc_bits_i),
        .en_i   (adc_en_i),
        .inv_i  (adc_inv_i),
        .sum_o  (sample)
    );

    corr_integ #(.SUM_W(SUM_W), .INT1_W(INT1_W), .ACC_W(ACC_W)) i_sin (
        .clk_i, .rst_ni,
        .sample_i (sample),
        .coef_i   ($signed(tbl_data_i[31:24])),
        .mode_i   (mode_now),
        .clear1_i (mode_chg),
        .snap_i,
        .result_o (res_sin_o),
        .int1_o   (int1_sin),
        .int2_o   (int2_sin)
    );

    corr_integ #(.SUM_W(SUM_W), .INT1_W(INT1_W), .ACC_W(ACC_W)) i_cos (
        .clk_i, .rst_ni,
        .sample_i (sample),
        .coef_i   ($signed(tbl_data_i[23:16])),
        .mode_i   (mode_now),
        .clear1_i (mode_chg),
        .snap_i,
        .result_o (res_cos_o),
        .int1_o   (int1_cos),
        .int2_o   (int2_cos)
    );

    always_comb begin
        state_d         = state_q;
        state_d.phase   = state_q.phase + freq_i;
        state_d.mode    = mode_now;
        state_d.dac_sin = tbl_data_i[15:8] ^ 8'h80;
        state_d.dac_cos = tbl_data_i[7:0]  ^ 8'h80;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= '{phase: '0, mode: MODE_SINGLE, dac_sin: 8'h80, dac_cos: 8'h80};
        end else begin
            state_q <= state_d;
        end
    end

    assign tbl_addr_o = state_q.phase[PHASE_W-1 -: ADDR_W];
    assign dac_sin_o  = state_q.dac_sin;
    assign dac_cos_o  = state_q.dac_cos;
endmodule

// File: rtl/corr_quad_chk.sv
module corr_quad_chk #(
    parameter int NUM_IN = 4,
    parameter int INT1_W = 24,
    parameter int ACC_W  = 32
) (
    input logic                     clk_i,
    input logic                     rst_ni,
    input logic                     mode_i,
    input logic                     snap_i,
    input logic                     mode_chg,
    input logic [31:0]              tbl_data_i,
    input logic [7:0]               dac_sin_o,
    input logic [7:0]               dac_cos_o,
    input logic [ACC_W-1:0]         res_sin_o,
    input logic [ACC_W-1:0]         res_cos_o,
    input logic signed [INT1_W-1:0] int1_sin,
    input logic signed [INT1_W-1:0] int1_cos,
    input logic [ACC_W-1:0]         int2_sin,
    input logic [ACC_W-1:0]         int2_cos
);
    localparam int HI = NUM_IN * 127;
    localparam int LO = -NUM_IN * 128;

    a_r7_mode_flush: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mode_chg |=> (int1_sin == '0 && int1_cos == '0));

    a_r4_single_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!mode_chg && !mode_i) |=>
            (int'(int1_cos) <= HI && int'(int1_cos) >= LO &&
             int'(int1_sin) <= HI && int'(int1_sin) >= LO));

    a_r8_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
        snap_i |=> (int2_sin == '0 && int2_cos == '0));

    a_r8_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
        snap_i |=> (res_sin_o == $past(int2_sin) && res_cos_o == $past(int2_cos)));

    a_r8_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !snap_i |=> ($stable(res_sin_o) && $stable(res_cos_o)));

    a_r9_dac_map: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rst_ni |=> (dac_sin_o == ($past(tbl_data_i[15:8]) ^ 8'h80) &&
                    dac_cos_o == ($past(tbl_data_i[7:0]) ^ 8'h80)));
endmodule

bind corr_quad_top corr_quad_chk #(.NUM_IN(NUM_IN), .INT1_W(INT1_W), .ACC_W(ACC_W)) i_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mode_i     (mode_i),
    .snap_i     (snap_i),
    .mode_chg   (mode_chg),
    .tbl_data_i (tbl_data_i),
    .dac_sin_o  (dac_sin_o),
    .dac_cos_o  (dac_cos_o),
    .res_sin_o  (res_sin_o),
    .res_cos_o  (res_cos_o),
    .int1_sin   (int1_sin),
    .int1_cos   (int1_cos),
    .int2_sin   (int2_sin),
    .int2_cos   (int2_cos)
);

// File: tb/test_corr_quad_top.sv
module test_corr_quad_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bits = '0, en = '0, inv = '0;
    logic [31:0] freq = '0;
    logic        mode = 1'b0, snap = 1'b0;
    logic [7:0]  addr;
    logic [31:0] tdata;
    logic [31:0] res_sin, res_cos;
    logic [7:0]  dac_sin, dac_cos;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    function automatic logic [31:0] tbl(input logic [7:0] a);
        return {a ^ 8'h5A, a + 8'd7, ~a, a * 8'd5};
    endfunction

    assign tdata = tbl(addr);

    corr_quad_top i_corr_quad_top (
        .clk_i(clk), .rst_ni(rst_n),
        .adc_bits_i(bits), .adc_en_i(en), .adc_inv_i(inv),
        .freq_i(freq), .mode_i(mode), .snap_i(snap),
        .tbl_addr_o(addr), .tbl_data_i(tdata),
        .res_sin_o(res_sin), .res_cos_o(res_cos),
        .dac_sin_o(dac_sin), .dac_cos_o(dac_cos)
    );

    // expected-value model built from the requirements
    logic [31:0] m_ph = '0;
    longint      m_i1s = 0, m_i1c = 0, m_i2s = 0, m_i2c = 0;
    longint      m_rs = 0, m_rc = 0;
    logic        m_mode = 1'b0;
    logic [7:0]  m_ds = 8'h80, m_dc = 8'h80;

    task automatic model_step();
        logic [31:0] w;
        int s;
        longint ps, pc, n1s, n1c;
        w = tbl(m_ph[31:24]);
        s = 0;
        for (int k = 0; k < 4; k++) if (en[k] && (bits[k] ^ inv[k])) s++;
        ps = longint'(s) * longint'($signed(w[31:24]));
        pc = longint'(s) * longint'($signed(w[23:16]));
        if (mode != m_mode) begin n1s = 0; n1c = 0; end
        else if (!mode) begin n1s = ps; n1c = pc; end
        else begin n1s = m_i1s + ps; n1c = m_i1c + pc; end
        if (snap) begin m_rs = m_i2s; m_rc = m_i2c; m_i2s = 0; m_i2c = 0; end
        else begin m_i2s = m_i2s + m_i1s; m_i2c = m_i2c + m_i1c; end
        m_i1s = n1s; m_i1c = n1c;
        m_ds = w[15:8] ^ 8'h80; m_dc = w[7:0] ^ 8'h80;
        m_ph = m_ph + freq; m_mode = mode;
    endtask

    task automatic cyc();
        @(posedge clk);
        model_step();
        @(negedge clk);
    endtask

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        check(res_sin == m_rs[31:0], {tag, " R8 res_sin"}, longint'(res_sin), longint'(m_rs[31:0]));
        check(res_cos == m_rc[31:0], {tag, " R8 res_cos"}, longint'(res_cos), longint'(m_rc[31:0]));
        check(dac_sin == m_ds && dac_cos == m_dc, {tag, " R9 dac"},
              longint'({dac_sin, dac_cos}), longint'({m_ds, m_dc}));
        check(addr == m_ph[31:24], {tag, " R2 addr"}, longint'(addr), longint'(m_ph[31:24]));
    endtask

    typedef struct packed {
        logic [3:0]  en, inv, bits;
        logic        mode, snap;
        logic [31:0] freq;
    } vec_t;

    localparam vec_t VEC [16] = '{
        '{4'hF, 4'h0, 4'hF, 1'b1, 1'b0, 32'h0100_0000},  // R5 R3
        '{4'hF, 4'h0, 4'hA, 1'b1, 1'b0, 32'h0300_0000},
        '{4'h5, 4'h0, 4'hF, 1'b1, 1'b0, 32'h0700_0000},  // R1 disabled pins
        '{4'hF, 4'hF, 4'h0, 1'b1, 1'b1, 32'h1000_0000},  // R1 inverted, R8
        '{4'h0, 4'h0, 4'hF, 1'b1, 1'b0, 32'h0000_0000},  // R1 nothing enabled
        '{4'hF, 4'h3, 4'h5, 1'b0, 1'b0, 32'h0200_0000},  // R7 change to single
        '{4'hF, 4'h3, 4'h5, 1'b1, 1'b0, 32'h0200_0000},  // R7 back to double
        '{4'hF, 4'h0, 4'hF, 1'b1, 1'b0, 32'h8000_0000},
        '{4'hF, 4'h0, 4'hF, 1'b1, 1'b0, 32'hF000_0000},
        '{4'h9, 4'h1, 4'h8, 1'b1, 1'b1, 32'h0480_0000},  // R8 snapshot
        '{4'hF, 4'h0, 4'h7, 1'b0, 1'b0, 32'h0100_0000},  // R4
        '{4'hF, 4'h0, 4'h7, 1'b0, 1'b0, 32'h0100_0000},
        '{4'hF, 4'h8, 4'h7, 1'b0, 1'b1, 32'h2000_0000},
        '{4'hE, 4'h2, 4'hC, 1'b1, 1'b0, 32'h0000_0001},
        '{4'hF, 4'h0, 4'hF, 1'b1, 1'b0, 32'h4000_0000},
        '{4'hF, 4'h0, 4'h0, 1'b1, 1'b1, 32'h0000_0000}
    };

    initial begin
        #2_000_000;
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        en = 4'hF; inv = 4'h0; bits = 4'hF; mode = 1'b0; freq = '0; snap = 1'b0;
        repeat (2) @(negedge clk);
        // R10 reset state
        check(res_sin == 0 && res_cos == 0, "R10 results", longint'(res_sin), 0);
        check(dac_sin == 8'h80 && dac_cos == 8'h80, "R10 dac", longint'({dac_sin, dac_cos}), 32896);
        check(addr == 8'h00, "R10 addr", longint'(addr), 0);
        rst_n = 1'b1;
        // R4 hand values: addr 0 gives sine 90, cosine 7, sample 4
        repeat (5) cyc();
        check(dac_sin == 8'h7F && dac_cos == 8'h80, "R9 addr0 dac", longint'({dac_sin, dac_cos}), 32640);
        snap = 1'b1;
        cyc();
        snap = 1'b0;
        check(res_cos == 32'd112, "R4 R6 cos total", longint'(res_cos), 112);
        check(res_sin == 32'd1440, "R4 R6 sin total", longint'(res_sin), 1440);
        check_all("post-hand");
        // vector walk
        for (int v = 0; v < 16; v++) begin
            en = VEC[v].en; inv = VEC[v].inv; bits = VEC[v].bits;
            mode = VEC[v].mode; snap = VEC[v].snap; freq = VEC[v].freq;
            cyc();
            check_all($sformatf("vec%0d", v));
        end
        // R7: double run, flush by single then back, then snapshot
        en = 4'hF; inv = 4'h0; bits = 4'hF; freq = '0; snap = 1'b0; mode = 1'b1;
        repeat (4) cyc();
        mode = 1'b0; cyc();
        mode = 1'b1; cyc();
        snap = 1'b1; cyc();
        snap = 1'b0;
        check_all("R7 flush");
        bits = 4'h0; snap = 1'b0;
        repeat (3) cyc();
        snap = 1'b1; cyc();
        snap = 1'b0;
        check_all("R5 R6 decay");
        // R8: results hold without strobe
        begin
            logic [31:0] hs;
            hs = res_sin;
            bits = 4'hF; repeat (3) cyc();
            check(res_sin == hs, "R8 hold", longint'(res_sin), longint'(hs));
        end
        // R2: phase stepping across many addresses
        freq = 32'h0123_4567;
        for (int k = 0; k < 20; k++) cyc();
        check_all("R2 R3 sweep");
        snap = 1'b1; cyc(); snap = 1'b0;
        check_all("R3 sweep snap");
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule